// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of the device side of a three-wire serial EEPROM. A host drives a chip-select line, a serial clock and a serial data input, and the block answers on a serial data output. Inside it is an array of 16-bit words: 64 words with a 6-bit address or 256 words with an 8-bit address. After a start bit it takes in a two-bit opcode and an address, and it carries out single-word read, write and erase, the two array-wide operations (fill with ones, fill with a given word), and the commands that open and close the programming lock.

All serial pins are brought into the block's own clock domain and sampled there, so the serial clock must be slow compared with the block clock. Every programming operation starts when chip select falls after a complete command. It then runs for a fixed number of block-clock cycles. While it runs, the data output is the ready/busy flag whenever chip select is high and no command is in progress. A host can therefore poll for completion in the same way it would with a real part.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, programming is locked, `sdo` is 0 while `cs` is low, and with `cs` high and no command in progress `sdo` shows ready (1).
- R2: Bits sampled as 0 on rising `sck` while no command is in progress are ignored. A command begins at the first 1 sampled with `cs` high.
- R3: Opcode 10 (read): after the last address bit the block drives a 0, then the 16 bits of the addressed word MSB first, one bit per rising `sck` edge.
- R4: Opcode 01 (write), with programming unlocked, stores the 16 data bits (MSB first) that follow the address at that address.
- R5: Opcode 11 (erase), with programming unlocked, sets the addressed word to FFFF hex and leaves the other words unchanged.
- R6: Opcode 00 with top address bits 10 sets every word to FFFF hex when programming is unlocked.
- R7: Opcode 00 with top address bits 01, followed by 16 data bits, writes that word to every address when programming is unlocked.
- R8: Opcode 00 with top address bits 11 unlocks programming and with 00 locks it; the lower address bits are ignored. While locked, every programming command has no effect and starts no busy period.
- R9: A programming command starts when `cs` falls. For BUSY_CYCLES block clocks after that, `sdo` reads 0 whenever `cs` is high outside a command, and then it returns to 1. Start bits are not accepted during this time.
- R10: Dropping `cs` before a command is complete discards that command. Nothing is programmed, and the next start bit begins a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the timebase for the busy period |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; data is sampled and shifted on its rising edge |
| sdi | input | 1 | Serial command, address and data input |
| sdo | output | 1 | Serial read data, or the ready/busy flag |

## Verification
The bench builds the block with a 6-bit address (64 words) and BUSY_CYCLES of 200. At this size it can write a distinct arithmetic pattern to every word and read every word back. It also runs both array-wide operations and checks every address afterwards. A busy period of 200 block clocks is longer than the 64-cycle array sweep, so the bench can measure the busy window exactly from the `sdo` transitions. It also exercises the lock, the unlock and lock commands with varied don't-care bits, and commands cut short by dropping `cs`.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_DATA,
    ST_READ,
    ST_DONE
  } dec_state_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise,
  output logic cs_fall
);
  logic [STAGES-1:0] cs_p, sk_p, di_p;
  logic sk_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '0;
      sk_p <= '0;
      di_p <= '0;
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      cs_p <= (cs_p << 1) | STAGES'(cs_i);
      sk_p <= (sk_p << 1) | STAGES'(sk_i);
      di_p <= (di_p << 1) | STAGES'(di_i);
      sk_q <= sk_p[STAGES-1];
      cs_q <= cs_p[STAGES-1];
    end
  end

  assign cs_s    = cs_p[STAGES-1];
  assign di_s    = di_p[STAGES-1];
  assign sk_rise = sk_p[STAGES-1] & ~sk_q;
  assign cs_fall = cs_q & ~cs_p[STAGES-1];
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mw_prog_engine.sv
module mw_prog_engine #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          all,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          busy
);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic           act, all_r;
  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= 1'b0;
      all_r <= 1'b0;
      waddr <= '0;
      wdata <= '0;
      bcnt  <= '0;
    end else if (start) begin
      act   <= 1'b1;
      all_r <= all;
      waddr <= all ? '0 : addr;
      wdata <= data;
      bcnt  <= BCW'(BUSY_CYCLES);
    end else begin
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (act) begin
        if (!all_r || waddr == LAST) act <= 1'b0;
        else waddr <= waddr + 1'b1;
      end
    end
  end

  assign we   = act;
  assign busy = act | (bcnt != '0);
endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_eeprom_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          di_s,
  input  logic          sk_rise,
  input  logic          cs_fall,
  input  logic          busy,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] rd_addr,
  output logic          prog_start,
  output logic          prog_all,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          wen,
  output logic          st_idle,
  output logic          dout
);
  localparam int HW   = 2 + AW;
  localparam int CNTW = $clog2(HW + DW + 1);

  dec_state_t      state;
  logic [HW-1:0]   hdr;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   dsh, rsh;
  logic [1:0]      ld_pipe;
  logic            pend;

  logic [HW-1:0] hdr_n;
  logic [DW-1:0] dsh_n;
  logic [1:0]    op_n, sub_n;
  logic [AW-1:0] adr_n;

  always_comb begin
    hdr_n = {hdr[HW-2:0], di_s};
    dsh_n = {dsh[DW-2:0], di_s};
    op_n  = hdr_n[HW-1:HW-2];
    sub_n = hdr_n[AW-1:AW-2];
    adr_n = hdr_n[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr       <= '0;
      cnt       <= '0;
      dsh       <= '0;
      rsh       <= '0;
      ld_pipe   <= '0;
      pend      <= 1'b0;
      prog_all  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      rd_addr   <= '0;
      wen       <= 1'b0;
      dout      <= 1'b0;
    end else begin
      ld_pipe <= {ld_pipe[0], 1'b0};
      if (ld_pipe[1]) rsh <= rdata;
      if (!cs_s) begin
        state <= ST_IDLE;
        dout  <= 1'b0;
        if (cs_fall) pend <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            dout <= ~busy;
            if (sk_rise && di_s && !busy) begin
              state <= ST_HEAD;
              cnt   <= '0;
              dout  <= 1'b0;
            end
          end
          ST_HEAD: if (sk_rise) begin
            hdr <= hdr_n;
            cnt <= cnt + 1'b1;
            if (cnt == CNTW'(HW - 1)) begin
              cnt <= '0;
              unique case (op_n)
                OP_READ: begin
                  state   <= ST_READ;
                  rd_addr <= adr_n;
                  ld_pipe <= 2'b01;
                  dout    <= 1'b0;
                end
                OP_WRITE: begin
                  state     <= ST_DATA;
                  prog_all  <= 1'b0;
                  prog_addr <= adr_n;
                end
                OP_ERASE: begin
                  state     <= ST_DONE;
                  pend      <= wen;
                  prog_all  <= 1'b0;
                  prog_addr <= adr_n;
                  prog_data <= '1;
                end
                default: begin
                  unique case (sub_n)
                    SUB_UNLOCK: begin wen <= 1'b1; state <= ST_DONE; end
                    SUB_LOCK:   begin wen <= 1'b0; state <= ST_DONE; end
                    SUB_CLEAR: begin
                      state     <= ST_DONE;
                      pend      <= wen;
                      prog_all  <= 1'b1;
                      prog_data <= '1;
                    end
                    default: begin
                      state    <= ST_DATA;
                      prog_all <= 1'b1;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: if (sk_rise) begin
            dsh <= dsh_n;
            cnt <= cnt + 1'b1;
            if (cnt == CNTW'(DW - 1)) begin
              state     <= ST_DONE;
              pend      <= wen;
              prog_data <= dsh_n;
            end
          end
          ST_READ: if (sk_rise) begin
            dout <= rsh[DW-1];
            rsh  <= {rsh[DW-2:0], 1'b0};
          end
          default: dout <= 1'b0;
        endcase
      end
    end
  end

  assign prog_start = cs_fall & pend;
  assign st_idle    = (state == ST_IDLE);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output logic sdo
);
  logic              cs_s, di_s, sk_rise, cs_fall;
  logic              busy, wen, st_idle, prog_start, prog_all;
  logic              ram_we;
  logic [ADDR_W-1:0] rd_addr, prog_addr, eng_addr, ram_addr;
  logic [DATA_W-1:0] prog_data, eng_data, rdata;

  mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sck), .di_i(sdi),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mw_cmd_decoder #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise),
    .cs_fall(cs_fall), .busy(busy), .rdata(rdata), .rd_addr(rd_addr),
    .prog_start(prog_start), .prog_all(prog_all), .prog_addr(prog_addr),
    .prog_data(prog_data), .wen(wen), .st_idle(st_idle), .dout(sdo)
  );

  mw_prog_engine #(.AW(ADDR_W), .DW(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .start(prog_start), .all(prog_all),
    .addr(prog_addr), .data(prog_data), .we(ram_we), .waddr(eng_addr),
    .wdata(eng_data), .busy(busy)
  );

  assign ram_addr = ram_we ? eng_addr : rd_addr;

  mw_word_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(eng_data), .rdata(rdata)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic dout,
  input logic st_idle,
  input logic busy,
  input logic wen,
  input logic prog_start
);
  p_locked_after_reset_r1: assert property (@(posedge clk) rst |=> !wen);

  p_quiet_without_cs_r1: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !dout);

  p_locked_no_program_r8: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> wen);

  p_start_makes_busy_r9: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> busy);

  p_busy_status_low_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_s && st_idle && busy) |=> !dout);

  p_no_command_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> st_idle);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .dout(sdo), .st_idle(st_idle),
  .busy(busy), .wen(wen), .prog_start(prog_start)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int BUSY  = 200;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .sdi(sdi), .sdo(sdo)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 40503) ^ 16'h3C96);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sck = 1'b0; sdi = b; wclk(4);
    sck = 1'b1; wclk(4);
  endtask

  task automatic cs_on();
    sck = 1'b0; cs = 1'b1; wclk(4);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [AW-1:0] a);
    bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = AW - 1; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic data_out(input logic [DW-1:0] d);
    for (int i = DW - 1; i >= 0; i--) bit_out(d[i]);
  endtask

  // cs low, reassert, poll the status on sdo
  task automatic finish(input bit expect_busy, input string req);
    int cyc;
    sck = 1'b0; cs = 1'b0; cyc = 0;
    wclk(4); cyc += 4;
    cs = 1'b1;
    wclk(8); cyc += 8;
    chk(sdo == !expect_busy, req, sdo, !expect_busy);
    while (sdo == 1'b0 && cyc < 5000) begin wclk(1); cyc++; end
    chk(sdo == 1'b1, req, sdo, 1);
    if (expect_busy)
      chk(cyc >= BUSY && cyc <= BUSY + 12, req, cyc, BUSY);
    cs = 1'b0; wclk(4);
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v, output logic dummy);
    cs_on();
    hdr(2'b10, AW'(a));
    sck = 1'b0; wclk(4);
    dummy = sdo;
    v = '0;
    for (int i = 0; i < DW; i++) begin
      sck = 1'b1; wclk(4);
      sck = 1'b0; wclk(4);
      v = {v[DW-2:0], sdo};
    end
    cs = 1'b0; wclk(4);
  endtask

  task automatic rd_chk(input int a, input logic [DW-1:0] exp, input string req);
    logic [DW-1:0] v;
    logic dm;
    rd(a, v, dm);
    chk(dm == 1'b0, "R3", dm, 0);
    chk(v == exp, req, v, exp);
  endtask

  task automatic ext(input logic [AW-1:0] a);
    cs_on(); hdr(2'b00, a); finish(1'b0, "R8");
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wclk(4); rst = 1'b0; wclk(4);
    // R1: reset state
    chk(sdo == 1'b0, "R1", sdo, 0);
    cs = 1'b1; wclk(8);
    chk(sdo == 1'b1, "R1", sdo, 1);
    cs = 1'b0; wclk(4);
    // R1/R8: locked after reset, write starts no busy period
    cs_on(); hdr(2'b01, 6'd0); data_out(16'h1234); finish(1'b0, "R1");
    // R8: unlock with varied don't-care bits
    ext({2'b11, 4'b1010});
    // R6: erase all
    cs_on(); hdr(2'b00, {2'b10, 4'b0110}); finish(1'b1, "R9");
    for (int a = 0; a < DEPTH; a++) rd_chk(a, 16'hFFFF, "R6");
    // R4 with R2 leading zeros on the first write
    for (int a = 0; a < DEPTH; a++) begin
      cs_on();
      if (a == 0) begin bit_out(1'b0); bit_out(1'b0); bit_out(1'b0); end
      hdr(2'b01, AW'(a)); data_out(pat(a)); finish(1'b1, "R9");
    end
    for (int a = 0; a < DEPTH; a++) rd_chk(a, pat(a), (a == 0) ? "R2" : "R4");
    // R5: single erase
    cs_on(); hdr(2'b11, 6'd10); finish(1'b1, "R9");
    rd_chk(10, 16'hFFFF, "R5");
    rd_chk(11, pat(11), "R5");
    rd_chk(9, pat(9), "R5");
    // R10: abort during data, then during header
    cs_on(); hdr(2'b01, 6'd20);
    for (int i = 0; i < 7; i++) bit_out(1'b0);
    finish(1'b0, "R10");
    rd_chk(20, pat(20), "R10");
    cs_on(); bit_out(1'b1); bit_out(1'b1); finish(1'b0, "R10");
    rd_chk(21, pat(21), "R10");
    // R8: lock with varied don't-care bits, then programming ignored
    ext({2'b00, 4'b0101});
    cs_on(); hdr(2'b11, 6'd30); finish(1'b0, "R8");
    rd_chk(30, pat(30), "R8");
    cs_on(); hdr(2'b00, {2'b01, 4'b0000}); data_out(16'h0F0F); finish(1'b0, "R8");
    cs_on(); hdr(2'b00, {2'b10, 4'b1111}); finish(1'b0, "R8");
    rd_chk(31, pat(31), "R8");
    // R7: write all
    ext({2'b11, 4'b0001});
    cs_on(); hdr(2'b00, {2'b01, 4'b1001}); data_out(16'hA5C3); finish(1'b1, "R9");
    for (int a = 0; a < DEPTH; a++) rd_chk(a, 16'hA5C3, "R7");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule